// File: doc/BRIEF.md
# Dual-Owner Program Memory Arbiter

This block is a single-port program RAM of 16-bit words that two masters share: a host CPU and a coprocessor. An ownership input selects the master that owns the RAM. The block registers that input, so a change takes effect at the next clock edge. Five requesters can ask for the port in the same cycle:

- CPU data (read or write)
- CPU program (read or write)
- CPU debug (read or write)
- CPU fetch
- coprocessor fetch

Each cycle at most one request is granted the RAM port, by a fixed priority that depends on the owner.

A request that the current mode does not allow is masked. It completes in the same cycle with its ready high and never touches the RAM. A masked read returns zero one cycle later, and a masked write is dropped. A masked CPU fetch raises a trap output, because the zero word it returns is an illegal opcode. A coprocessor fetch while the CPU owns the RAM raises an illegal-fetch flag. While the coprocessor is running, CPU debug accesses are masked, so a coprocessor looping on the port cannot lock out debug access.

A request that loses arbitration sees its ready held low. It must keep its address and data stable until ready goes high. Read data appears on the requester's own read-data output in the cycle after the one in which its ready was high. In every other cycle that output is zero.

Top module: `prog_mem_arbiter`

## Requirements
- R1: With ownership 0 (CPU), a CPU write wins over any read or fetch. Among writes, data wins over program, and program wins over debug. A losing requester sees ready low.
- R2: With ownership 0, a CPU read wins over a CPU fetch. Among reads, data wins over program, and program wins over debug. The granted read data appears on that requester's read-data output one cycle after ready.
- R3: With ownership 0, a CPU fetch with no competing CPU read or write is granted. It returns the stored word one cycle later.
- R4: With ownership 0, a coprocessor fetch has ready high in the same cycle and returns zero. It raises cop_illegal_fetch in the following cycle, and it does not block a CPU request made in the same cycle.
- R5: With ownership 1 (coprocessor), a coprocessor fetch has the highest priority and reads the RAM. A competing CPU debug access sees ready low.
- R6: With ownership 1, CPU data and program requests have ready high at once. Their reads return zero and their writes leave the RAM unchanged.
- R7: With ownership 1, a CPU fetch has ready high at once and returns zero. It raises cpu_illegal_trap in the following cycle.
- R8: With ownership 1 and cop_running high, CPU debug requests have ready high at once, even against a coprocessor fetch. Debug reads return zero and debug writes leave the RAM unchanged.
- R9: With ownership 1 and cop_running low, CPU debug reads and writes access the RAM normally when no coprocessor fetch competes.
- R10: A change of owner_cop is applied at the next clock edge. A request made in the same cycle as the change is handled under the old mode.
- R11: After reset, the owner is the CPU, every read-data output is zero and both flags are low. At most one request uses the RAM port in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| owner_cop | input | 1 | Ownership: 0 = CPU, 1 = coprocessor (registered) |
| cop_running | input | 1 | Coprocessor executing (direct) |
| cpu_data_req | input | 1 | CPU data request |
| cpu_data_we | input | 1 | CPU data write enable |
| cpu_data_addr | input | 11 | CPU data word address |
| cpu_data_wdata | input | 16 | CPU data write word |
| cpu_data_ready | output | 1 | CPU data request accepted |
| cpu_data_rdata | output | 16 | CPU data read word |
| cpu_prog_req | input | 1 | CPU program request |
| cpu_prog_we | input | 1 | CPU program write enable |
| cpu_prog_addr | input | 11 | CPU program word address |
| cpu_prog_wdata | input | 16 | CPU program write word |
| cpu_prog_ready | output | 1 | CPU program request accepted |
| cpu_prog_rdata | output | 16 | CPU program read word |
| cpu_dbg_req | input | 1 | CPU debug request |
| cpu_dbg_we | input | 1 | CPU debug write enable |
| cpu_dbg_addr | input | 11 | CPU debug word address |
| cpu_dbg_wdata | input | 16 | CPU debug write word |
| cpu_dbg_ready | output | 1 | CPU debug request accepted |
| cpu_dbg_rdata | output | 16 | CPU debug read word |
| cpu_fetch_req | input | 1 | CPU instruction fetch |
| cpu_fetch_addr | input | 11 | CPU fetch address |
| cpu_fetch_ready | output | 1 | CPU fetch accepted |
| cpu_fetch_rdata | output | 16 | CPU fetched word |
| cop_fetch_req | input | 1 | Coprocessor fetch |
| cop_fetch_addr | input | 11 | Coprocessor fetch address |
| cop_fetch_ready | output | 1 | Coprocessor fetch accepted |
| cop_fetch_rdata | output | 16 | Coprocessor fetched word |
| cpu_illegal_trap | output | 1 | Masked CPU fetch occurred last cycle |
| cop_illegal_fetch | output | 1 | Coprocessor fetch under CPU ownership last cycle |

## Verification
The bench first raises all three CPU writes, all three CPU reads and a fetch in the same cycle, then withdraws the winner each cycle. This cascade separates a wrong write order, a wrong read order and reads ranked wrongly against the fetch. Mixes of a masked requester with a granted one show whether masked requests still take the port or stall the granted one. Writes attempted while masked are later read back under CPU ownership, which separates a dropped write from one that only returned ready. A request made in the same cycle as an ownership change shows whether the mode is registered or applied at once.

// File: rtl/pmem_arb_pkg.sv
package pmem_arb_pkg;
  // Requester slots; the lower NUM_RW slots can both read and write,
  // and their index order is the in-class priority in CPU mode.
  localparam int NREQ      = 5;
  localparam int NUM_RW    = 3;
  localparam int SLOT_DATA = 0;
  localparam int SLOT_PROG = 1;
  localparam int SLOT_DBG  = 2;
  localparam int SLOT_CFET = 3;
  localparam int SLOT_KFET = 4;
endpackage

// File: rtl/pmem_arb_decode.sv
module pmem_arb_decode
  import pmem_arb_pkg::*;
(
  input  logic            own_cop,
  input  logic            cop_run,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] wr,
  output logic [NREQ-1:0] grant,
  output logic [NREQ-1:0] masked
);
  logic taken;

  always_comb begin
    grant  = '0;
    masked = '0;
    taken  = 1'b0;
    if (!own_cop) begin
      masked[SLOT_KFET] = req[SLOT_KFET];
      for (int i = 0; i < NUM_RW; i++) begin
        if (!taken && req[i] && wr[i]) begin
          grant[i] = 1'b1;
          taken    = 1'b1;
        end
      end
      for (int i = 0; i < NUM_RW; i++) begin
        if (!taken && req[i] && !wr[i]) begin
          grant[i] = 1'b1;
          taken    = 1'b1;
        end
      end
      if (!taken && req[SLOT_CFET]) grant[SLOT_CFET] = 1'b1;
    end else begin
      masked[SLOT_DATA] = req[SLOT_DATA];
      masked[SLOT_PROG] = req[SLOT_PROG];
      masked[SLOT_CFET] = req[SLOT_CFET];
      masked[SLOT_DBG]  = req[SLOT_DBG] && cop_run;
      if (req[SLOT_KFET])                grant[SLOT_KFET] = 1'b1;
      else if (req[SLOT_DBG] && !cop_run) grant[SLOT_DBG]  = 1'b1;
    end
  end
endmodule

// File: rtl/pmem_sp_ram.sv
module pmem_sp_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/prog_mem_arbiter.sv
module prog_mem_arbiter
  import pmem_arb_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          owner_cop,
  input  logic          cop_running,
  input  logic          cpu_data_req,
  input  logic          cpu_data_we,
  input  logic [AW-1:0] cpu_data_addr,
  input  logic [DW-1:0] cpu_data_wdata,
  output logic          cpu_data_ready,
  output logic [DW-1:0] cpu_data_rdata,
  input  logic          cpu_prog_req,
  input  logic          cpu_prog_we,
  input  logic [AW-1:0] cpu_prog_addr,
  input  logic [DW-1:0] cpu_prog_wdata,
  output logic          cpu_prog_ready,
  output logic [DW-1:0] cpu_prog_rdata,
  input  logic          cpu_dbg_req,
  input  logic          cpu_dbg_we,
  input  logic [AW-1:0] cpu_dbg_addr,
  input  logic [DW-1:0] cpu_dbg_wdata,
  output logic          cpu_dbg_ready,
  output logic [DW-1:0] cpu_dbg_rdata,
  input  logic          cpu_fetch_req,
  input  logic [AW-1:0] cpu_fetch_addr,
  output logic          cpu_fetch_ready,
  output logic [DW-1:0] cpu_fetch_rdata,
  input  logic          cop_fetch_req,
  input  logic [AW-1:0] cop_fetch_addr,
  output logic          cop_fetch_ready,
  output logic [DW-1:0] cop_fetch_rdata,
  output logic          cpu_illegal_trap,
  output logic          cop_illegal_fetch
);
  logic [NREQ-1:0] req_v, wr_v, grant, masked, rd_sel_q, rd_sel_d;
  logic [AW-1:0]   addr_a  [NREQ];
  logic [DW-1:0]   wdata_a [NREQ];
  logic [DW-1:0]   rdata_a [NREQ];
  logic            own_q, own_d, trap_q, trap_d, kill_q, kill_d;
  logic            ram_en, ram_wr;
  logic [AW-1:0]   ram_addr;
  logic [DW-1:0]   ram_wdata, ram_q;

  // Gather requesters into slot vectors
  always_comb begin
    req_v = {cop_fetch_req, cpu_fetch_req, cpu_dbg_req, cpu_prog_req, cpu_data_req};
    wr_v  = {1'b0, 1'b0, cpu_dbg_we, cpu_prog_we, cpu_data_we};
    addr_a[SLOT_DATA]  = cpu_data_addr;
    addr_a[SLOT_PROG]  = cpu_prog_addr;
    addr_a[SLOT_DBG]   = cpu_dbg_addr;
    addr_a[SLOT_CFET]  = cpu_fetch_addr;
    addr_a[SLOT_KFET]  = cop_fetch_addr;
    wdata_a[SLOT_DATA] = cpu_data_wdata;
    wdata_a[SLOT_PROG] = cpu_prog_wdata;
    wdata_a[SLOT_DBG]  = cpu_dbg_wdata;
    wdata_a[SLOT_CFET] = '0;
    wdata_a[SLOT_KFET] = '0;
  end

  pmem_arb_decode u_dec (
    .own_cop (own_q),
    .cop_run (cop_running),
    .req     (req_v),
    .wr      (wr_v),
    .grant   (grant),
    .masked  (masked)
  );

  // One-hot grant selects the port address and write word
  always_comb begin
    ram_addr  = '0;
    ram_wdata = '0;
    ram_wr    = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        ram_addr  = addr_a[i];
        ram_wdata = wdata_a[i];
        ram_wr    = wr_v[i];
      end
    end
    ram_en = |grant;
  end

  pmem_sp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .wr    (ram_wr),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  // Next state
  always_comb begin
    own_d    = owner_cop;
    rd_sel_d = grant & ~wr_v;
    trap_d   = masked[SLOT_CFET];
    kill_d   = masked[SLOT_KFET];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= 1'b0;
      rd_sel_q <= '0;
      trap_q   <= 1'b0;
      kill_q   <= 1'b0;
    end else begin
      own_q    <= own_d;
      rd_sel_q <= rd_sel_d;
      trap_q   <= trap_d;
      kill_q   <= kill_d;
    end
  end

  // Only the slot granted a read last cycle sees RAM data; others see zero
  for (genvar g = 0; g < NREQ; g++) begin : g_rd
    assign rdata_a[g] = rd_sel_q[g] ? ram_q : '0;
  end

  always_comb begin
    cpu_data_ready    = grant[SLOT_DATA] | masked[SLOT_DATA];
    cpu_prog_ready    = grant[SLOT_PROG] | masked[SLOT_PROG];
    cpu_dbg_ready     = grant[SLOT_DBG]  | masked[SLOT_DBG];
    cpu_fetch_ready   = grant[SLOT_CFET] | masked[SLOT_CFET];
    cop_fetch_ready   = grant[SLOT_KFET] | masked[SLOT_KFET];
    cpu_data_rdata    = rdata_a[SLOT_DATA];
    cpu_prog_rdata    = rdata_a[SLOT_PROG];
    cpu_dbg_rdata     = rdata_a[SLOT_DBG];
    cpu_fetch_rdata   = rdata_a[SLOT_CFET];
    cop_fetch_rdata   = rdata_a[SLOT_KFET];
    cpu_illegal_trap  = trap_q;
    cop_illegal_fetch = kill_q;
  end
endmodule

// File: rtl/pmem_arb_chk.sv
module pmem_arb_chk
  import pmem_arb_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            own_q,
  input logic            cop_running,
  input logic [NREQ-1:0] grant,
  input logic            cpu_data_req,
  input logic            cpu_data_we,
  input logic            cpu_data_ready,
  input logic            cpu_dbg_req,
  input logic            cpu_dbg_we,
  input logic            cpu_dbg_ready,
  input logic [DW-1:0]   cpu_dbg_rdata,
  input logic            cpu_fetch_req,
  input logic [DW-1:0]   cpu_fetch_rdata,
  input logic            cop_fetch_req,
  input logic            cop_fetch_ready,
  input logic [DW-1:0]   cop_fetch_rdata,
  input logic            cpu_illegal_trap,
  input logic            cop_illegal_fetch
);
  assert_single_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_write_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_q && cpu_data_req && cpu_data_we) |-> cpu_data_ready);

  assert_cop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_q && cop_fetch_req) |=> (cop_illegal_fetch && cop_fetch_rdata == '0));

  assert_cop_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && cop_fetch_req) |-> (cop_fetch_ready && !(cpu_dbg_ready && !cop_running)));

  assert_cpu_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && cpu_data_req) |-> cpu_data_ready);

  assert_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && cpu_fetch_req) |=> (cpu_illegal_trap && cpu_fetch_rdata == '0));

  assert_dbg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && cop_running && cpu_dbg_req && !cpu_dbg_we) |=> (cpu_dbg_rdata == '0));
endmodule

bind prog_mem_arbiter pmem_arb_chk #(.DW(DW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .own_q             (own_q),
  .cop_running       (cop_running),
  .grant             (grant),
  .cpu_data_req      (cpu_data_req),
  .cpu_data_we       (cpu_data_we),
  .cpu_data_ready    (cpu_data_ready),
  .cpu_dbg_req       (cpu_dbg_req),
  .cpu_dbg_we        (cpu_dbg_we),
  .cpu_dbg_ready     (cpu_dbg_ready),
  .cpu_dbg_rdata     (cpu_dbg_rdata),
  .cpu_fetch_req     (cpu_fetch_req),
  .cpu_fetch_rdata   (cpu_fetch_rdata),
  .cop_fetch_req     (cop_fetch_req),
  .cop_fetch_ready   (cop_fetch_ready),
  .cop_fetch_rdata   (cop_fetch_rdata),
  .cpu_illegal_trap  (cpu_illegal_trap),
  .cop_illegal_fetch (cop_illegal_fetch)
);

// File: tb/prog_mem_arbiter_tb.sv
module prog_mem_arbiter_tb;
  logic        clk, rst_n, owner_cop, cop_running;
  logic        cpu_data_req, cpu_data_we, cpu_data_ready;
  logic [10:0] cpu_data_addr;
  logic [15:0] cpu_data_wdata, cpu_data_rdata;
  logic        cpu_prog_req, cpu_prog_we, cpu_prog_ready;
  logic [10:0] cpu_prog_addr;
  logic [15:0] cpu_prog_wdata, cpu_prog_rdata;
  logic        cpu_dbg_req, cpu_dbg_we, cpu_dbg_ready;
  logic [10:0] cpu_dbg_addr;
  logic [15:0] cpu_dbg_wdata, cpu_dbg_rdata;
  logic        cpu_fetch_req, cpu_fetch_ready;
  logic [10:0] cpu_fetch_addr;
  logic [15:0] cpu_fetch_rdata;
  logic        cop_fetch_req, cop_fetch_ready;
  logic [10:0] cop_fetch_addr;
  logic [15:0] cop_fetch_rdata;
  logic        cpu_illegal_trap, cop_illegal_fetch;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  prog_mem_arbiter u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_data_req = 0; cpu_prog_req = 0; cpu_dbg_req = 0;
    cpu_fetch_req = 0; cop_fetch_req = 0;
  endtask

  // advance to the next falling edge; inputs then settle for 1 ns
  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R11 data rdata", cpu_data_rdata, 16'h0);
    chk("R11 cop rdata", cop_fetch_rdata, 16'h0);
    chk("R11 trap", {15'b0, cpu_illegal_trap}, 16'h0);
    chk("R11 illegal", {15'b0, cop_illegal_fetch}, 16'h0);
  endtask

  task automatic t_cpu_write_order();
    cpu_data_req = 1; cpu_data_we = 1; cpu_data_addr = 5; cpu_data_wdata = 16'h1234;
    cpu_prog_req = 1; cpu_prog_we = 1; cpu_prog_addr = 6; cpu_prog_wdata = 16'hBEEF;
    cpu_dbg_req  = 1; cpu_dbg_we  = 1; cpu_dbg_addr  = 7; cpu_dbg_wdata  = 16'h0A0A;
    cpu_fetch_req = 1; cpu_fetch_addr = 6;
    #1;
    chk("R1 data wins", {13'b0, cpu_data_ready, cpu_prog_ready, cpu_dbg_ready}, 16'b100);
    chk("R1 fetch held", {15'b0, cpu_fetch_ready}, 16'h0);
    step(); cpu_data_req = 0; #1;
    chk("R1 prog next", {13'b0, cpu_data_ready, cpu_prog_ready, cpu_dbg_ready}, 16'b010);
    step(); cpu_prog_req = 0; #1;
    chk("R1 dbg next", {14'b0, cpu_dbg_ready, cpu_fetch_ready}, 16'b10);
    step(); cpu_dbg_req = 0; cpu_fetch_req = 0;
  endtask

  task automatic t_cpu_read_order();
    cpu_data_req = 1; cpu_data_we = 0; cpu_data_addr = 5;
    cpu_prog_req = 1; cpu_prog_we = 0; cpu_prog_addr = 6;
    cpu_dbg_req  = 1; cpu_dbg_we  = 0; cpu_dbg_addr  = 7;
    cpu_fetch_req = 1; cpu_fetch_addr = 6;
    #1;
    chk("R2 data read wins", {12'b0, cpu_data_ready, cpu_prog_ready, cpu_dbg_ready, cpu_fetch_ready}, 16'b1000);
    step(); cpu_data_req = 0; #1;
    chk("R2 data rdata", cpu_data_rdata, 16'h1234);
    chk("R2 prog next", {12'b0, cpu_data_ready, cpu_prog_ready, cpu_dbg_ready, cpu_fetch_ready}, 16'b0100);
    step(); cpu_prog_req = 0; #1;
    chk("R2 prog rdata", cpu_prog_rdata, 16'hBEEF);
    chk("R2 data rdata cleared", cpu_data_rdata, 16'h0);
    chk("R2 dbg before fetch", {14'b0, cpu_dbg_ready, cpu_fetch_ready}, 16'b10);
    step(); cpu_dbg_req = 0; #1;
    chk("R2 dbg rdata", cpu_dbg_rdata, 16'h0A0A);
    chk("R3 fetch granted", {15'b0, cpu_fetch_ready}, 16'h1);
    step(); cpu_fetch_req = 0; #1;
    chk("R3 fetch rdata", cpu_fetch_rdata, 16'hBEEF);
    step();
  endtask

  task automatic t_cop_in_cpu_mode();
    cop_fetch_req = 1; cop_fetch_addr = 5;
    cpu_data_req = 1; cpu_data_we = 0; cpu_data_addr = 7;
    #1;
    chk("R4 both ready", {14'b0, cop_fetch_ready, cpu_data_ready}, 16'b11);
    step(); idle(); #1;
    chk("R4 cop zero", cop_fetch_rdata, 16'h0);
    chk("R4 illegal flag", {15'b0, cop_illegal_fetch}, 16'h1);
    chk("R4 cpu unaffected", cpu_data_rdata, 16'h0A0A);
    step();
    chk("R4 flag drops", {15'b0, cop_illegal_fetch}, 16'h0);
  endtask

  task automatic t_switch();
    owner_cop = 1; cop_fetch_req = 1; cop_fetch_addr = 5; #1;
    chk("R10 old mode masked", {15'b0, cop_fetch_ready}, 16'h1);
    step(); #1;
    chk("R10 old mode flag", {15'b0, cop_illegal_fetch}, 16'h1);
    step(); cop_fetch_req = 0; #1;
    chk("R10 new mode fetch", cop_fetch_rdata, 16'h1234);
    chk("R10 no flag", {15'b0, cop_illegal_fetch}, 16'h0);
    step();
  endtask

  task automatic t_cop_mode_halted();
    cop_fetch_req = 1; cop_fetch_addr = 6;
    cpu_dbg_req = 1; cpu_dbg_we = 0; cpu_dbg_addr = 7; #1;
    chk("R5 cop beats dbg", {14'b0, cop_fetch_ready, cpu_dbg_ready}, 16'b10);
    step(); cop_fetch_req = 0; #1;
    chk("R5 cop rdata", cop_fetch_rdata, 16'hBEEF);
    chk("R9 dbg granted", {15'b0, cpu_dbg_ready}, 16'h1);
    step(); cpu_dbg_req = 0; #1;
    chk("R9 dbg read", cpu_dbg_rdata, 16'h0A0A);
    cpu_dbg_req = 1; cpu_dbg_we = 1; cpu_dbg_addr = 8; cpu_dbg_wdata = 16'h5555;
    step(); cpu_dbg_we = 0; step(); cpu_dbg_req = 0; #1;
    chk("R9 dbg write then read", cpu_dbg_rdata, 16'h5555);
    step();
  endtask

  task automatic t_cpu_masked();
    cpu_data_req = 1; cpu_data_we = 0; cpu_data_addr = 5;
    cop_fetch_req = 1; cop_fetch_addr = 7; #1;
    chk("R6 data ready at once", {14'b0, cpu_data_ready, cop_fetch_ready}, 16'b11);
    step(); idle(); #1;
    chk("R6 data zero", cpu_data_rdata, 16'h0);
    chk("R6 cop still served", cop_fetch_rdata, 16'h0A0A);
    cpu_data_req = 1; cpu_data_we = 1; cpu_data_wdata = 16'hFFFF;
    cpu_prog_req = 1; cpu_prog_we = 1; cpu_prog_addr = 6; cpu_prog_wdata = 16'hFFFF; #1;
    chk("R6 writes ready", {14'b0, cpu_data_ready, cpu_prog_ready}, 16'b11);
    step(); idle();
    cpu_fetch_req = 1; cpu_fetch_addr = 5; #1;
    chk("R7 fetch ready", {15'b0, cpu_fetch_ready}, 16'h1);
    step(); idle(); #1;
    chk("R7 fetch zero", cpu_fetch_rdata, 16'h0);
    chk("R7 trap", {15'b0, cpu_illegal_trap}, 16'h1);
    step();
  endtask

  task automatic t_running();
    cop_running = 1;
    cop_fetch_req = 1; cop_fetch_addr = 5;
    cpu_dbg_req = 1; cpu_dbg_we = 0; cpu_dbg_addr = 7; #1;
    chk("R8 dbg ready vs cop", {14'b0, cpu_dbg_ready, cop_fetch_ready}, 16'b11);
    step(); idle(); #1;
    chk("R8 dbg zero", cpu_dbg_rdata, 16'h0);
    cpu_dbg_req = 1; cpu_dbg_we = 1; cpu_dbg_wdata = 16'h1111; #1;
    chk("R8 dbg write ready", {15'b0, cpu_dbg_ready}, 16'h1);
    step(); idle(); cop_running = 0;
    cpu_dbg_req = 1; cpu_dbg_we = 0; cpu_dbg_addr = 7;
    step(); idle(); #1;
    chk("R8 dbg write dropped", cpu_dbg_rdata, 16'h0A0A);
    step();
  endtask

  task automatic t_back_to_cpu();
    owner_cop = 0; step();
    cpu_data_req = 1; cpu_data_we = 0; cpu_data_addr = 5;
    step(); idle(); #1;
    chk("R6 data write dropped", cpu_data_rdata, 16'h1234);
    cpu_prog_req = 1; cpu_prog_we = 0; cpu_prog_addr = 6;
    step(); idle(); #1;
    chk("R6 prog write dropped", cpu_prog_rdata, 16'hBEEF);
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; owner_cop = 0; cop_running = 0;
    cpu_data_we = 0; cpu_prog_we = 0; cpu_dbg_we = 0;
    cpu_data_addr = 0; cpu_prog_addr = 0; cpu_dbg_addr = 0;
    cpu_fetch_addr = 0; cop_fetch_addr = 0;
    cpu_data_wdata = 0; cpu_prog_wdata = 0; cpu_dbg_wdata = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    step();
    t_cpu_write_order();
    t_cpu_read_order();
    t_cop_in_cpu_mode();
    t_switch();
    t_cop_mode_halted();
    t_cpu_masked();
    t_running();
    t_back_to_cpu();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule